// File: doc/BRIEF.md
# Condition Field Mask-Compare Unit

This unit executes a small family of condition-register instructions in one clock. It receives an instruction word, the packed 32-bit condition register and an integer source operand. Each instruction compares the four bits of a source value against a 4-bit mode pattern, one bit position at a time, and qualifies each comparison with a 4-bit mask. The four resulting terms are then either kept as a new 4-bit field or reduced to one bit by AND or OR.

Two instruction bits choose one of four variants. The first reduces a field to one bit, written into an integer destination. The second builds a field from the integer least-significant bit. The third writes a whole field from another field. The fourth writes one chosen bit of one field. A source register index of zero reads as a literal zero, so the integer-to-field variant can also set, clear or load a field from the immediate bits alone.

The unit returns the complete updated condition register with a write strobe, or the integer result with its destination index. The register files sit outside the unit and act on the strobes. Fields are numbered in natural order: field k is nibble k of the packed register.

Top module: `cfmc_unit`

## Requirements
- R1: A write strobe is raised only for an instruction whose primary opcode (big-endian bits 0-5, i.e. `instrWord[31:26]`) equals 19, whose sub-opcode (big-endian bits 21-25, `instrWord[10:6]`) equals parameter `SUB_OP` (default 5'b01011), and whose big-endian bit 26 (`instrWord[5]`) is 0. Any other word raises neither `intWrEn` nor `crWrEn`. At most one strobe is high in any cycle.
- R2: All results are registered. `resValid`, the strobes and the data appear one clock after `issueValid` and its operands are sampled. Reset clears `resValid`, `intWrEn` and `crWrEn`.
- R3: For position i in 0..3, term n_i = mask[i] AND (mode[i] == src[i]). mask[i] is big-endian bit 12+i (`instrWord[19-i]`). mode[i] is big-endian bit 27+i (`instrWord[4-i]`). The reduction flag is big-endian bit 20 (`instrWord[11]`): 1 selects OR of the four terms, 0 selects AND.
- R4: The variant is chosen by A = big-endian bit 11 (`instrWord[20]`) and B = big-endian bit 19 (`instrWord[12]`): A=0,B=0 field-to-integer; A=1,B=0 integer-to-field; A=0,B=1 field-to-field; A=1,B=1 field-to-single-bit. Field k is `crIn[4k+3:4k]`. Position i of a field is bit 4k+3-i, so position 0 (lt) is the most significant bit of the nibble.
- R5: Field-to-integer: src is field BB (big-endian bits 16-18, `instrWord[15:13]`). `intResult` holds the reduction in bit 0 and zeros elsewhere. `intDestIdx` is big-endian bits 6-10 (`instrWord[25:21]`).
- R6: Integer-to-field: every src[i] equals one bit. That bit is 0 when the index in big-endian bits 6-10 is zero, and `srcVal[0]` otherwise. Field BB becomes {n0,n1,n2,n3}, with n0 in the nibble's top bit. `srcRegIdx` always shows big-endian bits 6-10.
- R7: Field-to-field: src is field BB. The field named by big-endian bits 6-8 (`instrWord[25:23]`) becomes {n0,n1,n2,n3}.
- R8: Field-to-single-bit: src is field BB. Field F = big-endian bits 8-10 (`instrWord[23:21]`) and position p = bits 6-7 (`instrWord[25:24]`). Only bit 4F+3-p changes, and it takes the reduction value.
- R9: Whenever `crWrEn` is high, every bit of `crOut` outside the target field equals the `crIn` sampled with the instruction.
- R10: Integer-to-field with a zero index yields field = mask AND NOT mode per position. Mode 0000 sets the masked positions, mask 1111 with mode 1111 clears the field, and mask 1111 with an inverted pattern loads that pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Instruction and operands are valid this cycle |
| instrWord | input | 32 | Instruction word |
| crIn | input | 32 | Packed condition register, field k at bits 4k+3..4k |
| srcVal | input | 64 | Integer source operand read at `srcRegIdx` |
| srcRegIdx | output | 5 | Integer source index decoded from the word (combinational) |
| resValid | output | 1 | Result slot valid, one cycle after issue |
| intWrEn | output | 1 | Write `intResult` to `intDestIdx` |
| intDestIdx | output | 5 | Integer destination index |
| intResult | output | 64 | Integer result |
| crWrEn | output | 1 | Write `crOut` to the condition register |
| crOut | output | 32 | Updated packed condition register |

## Verification
The hardest case to reach from the ports is the one where the single-bit variant and the whole-field variants must leave every other bit untouched. A change to a neighbouring bit or field only shows when the surrounding bits carry values that differ from what the unit would write. The stimulus therefore pairs each directed case with a condition register full of contrasting bits. A long random run then draws mask, mode, every field and every selector freely, with a share of wrong opcodes and idle cycles mixed in. The literal-zero source of the integer-to-field variant is forced in both directions with an odd operand, so that a design that reads the register anyway is exposed.

// File: rtl/cfmc_pkg.sv
package cfmc_pkg;
  localparam int FIELD_W   = 4;
  localparam int FIELD_CNT = 8;
  localparam int FIELD_IW  = $clog2(FIELD_CNT);
  localparam int CR_W      = FIELD_W * FIELD_CNT;
  localparam int POS_IW    = $clog2(FIELD_W);

  typedef enum logic [1:0] {
    VAR_CR2INT = 2'b00,
    VAR_INT2CR = 2'b01,
    VAR_CR2CR  = 2'b10,
    VAR_CR2BIT = 2'b11
  } variant_e;

  typedef struct packed {
    logic                act;
    variant_e            variant;
    logic                reduceOr;
    logic [FIELD_W-1:0]  maskV;
    logic [FIELD_W-1:0]  modeV;
    logic [FIELD_IW-1:0] srcField;
    logic [FIELD_IW-1:0] dstField;
    logic [POS_IW-1:0]   bitSel;
    logic                srcZero;
    logic [4:0]          regIdx;
  } cfmcStrobe_t;
endpackage

// File: rtl/cfmc_ctrl.sv
module cfmc_ctrl
  import cfmc_pkg::*;
#(
  parameter logic [5:0] PRIMARY_OP = 6'd19,
  parameter logic [4:0] SUB_OP     = 5'b01011
) (
  input  logic [31:0] instrWord,
  output cfmcStrobe_t strobe
);
  logic opMatch;
  logic selA;
  logic selB;
  logic unusedRc;

  assign selA     = instrWord[20];
  assign selB     = instrWord[12];
  assign unusedRc = instrWord[0];
  assign opMatch  = (instrWord[31:26] == PRIMARY_OP) &&
                    (instrWord[10:6] == SUB_OP) &&
                    (instrWord[5] == 1'b0);

  always_comb begin
    strobe          = '0;
    strobe.act      = opMatch;
    strobe.variant  = variant_e'({selB, selA});
    strobe.reduceOr = instrWord[11];
    for (int i = 0; i < FIELD_W; i++) begin
      strobe.maskV[i] = instrWord[19-i];
      strobe.modeV[i] = instrWord[4-i];
    end
    strobe.srcField = instrWord[15:13];
    strobe.regIdx   = instrWord[25:21];
    strobe.srcZero  = (instrWord[25:21] == 5'd0);
    strobe.bitSel   = instrWord[25:24];
    unique case (strobe.variant)
      VAR_INT2CR: strobe.dstField = instrWord[15:13];
      VAR_CR2CR:  strobe.dstField = instrWord[25:23];
      VAR_CR2BIT: strobe.dstField = instrWord[23:21];
      default:    strobe.dstField = '0;
    endcase
  end
endmodule

// File: rtl/cfmc_datapath.sv
module cfmc_datapath
  import cfmc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  cfmcStrobe_t      strobe,
  input  logic [CR_W-1:0]  crIn,
  input  logic [XLEN-1:0]  srcVal,
  output logic             resValid,
  output logic             intWrEn,
  output logic [4:0]       intDestIdx,
  output logic [XLEN-1:0]  intResult,
  output logic             crWrEn,
  output logic [CR_W-1:0]  crOut
);
  logic [FIELD_W-1:0] srcNib;
  logic [FIELD_W-1:0] srcBits;
  logic [FIELD_W-1:0] terms;
  logic [FIELD_W-1:0] newField;
  logic               intLsb;
  logic               reduced;
  logic [CR_W-1:0]    crNext;
  logic [XLEN-1:1]    unusedSrc;

  assign unusedSrc = srcVal[XLEN-1:1];
  assign srcNib    = crIn[strobe.srcField*FIELD_W +: FIELD_W];
  assign intLsb    = strobe.srcZero ? 1'b0 : srcVal[0];

  for (genvar i = 0; i < FIELD_W; i++) begin : g_term
    assign srcBits[i]                = (strobe.variant == VAR_INT2CR) ? intLsb
                                                                      : srcNib[FIELD_W-1-i];
    assign terms[i]                  = strobe.maskV[i] & (strobe.modeV[i] ~^ srcBits[i]);
    assign newField[FIELD_W-1-i]     = terms[i];
  end

  assign reduced = strobe.reduceOr ? (|terms) : (&terms);

  for (genvar k = 0; k < FIELD_CNT; k++) begin : g_field
    logic [FIELD_W-1:0] oldNib;
    logic [FIELD_W-1:0] bitNib;
    logic               isTarget;
    assign oldNib   = crIn[k*FIELD_W +: FIELD_W];
    assign isTarget = (strobe.dstField == FIELD_IW'(k));
    always_comb begin
      bitNib = oldNib;
      bitNib[FIELD_W-1-int'(strobe.bitSel)] = reduced;
    end
    always_comb begin
      crNext[k*FIELD_W +: FIELD_W] = oldNib;
      if (isTarget) begin
        unique case (strobe.variant)
          VAR_INT2CR, VAR_CR2CR: crNext[k*FIELD_W +: FIELD_W] = newField;
          VAR_CR2BIT:            crNext[k*FIELD_W +: FIELD_W] = bitNib;
          default:               crNext[k*FIELD_W +: FIELD_W] = oldNib;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      intWrEn    <= 1'b0;
      crWrEn     <= 1'b0;
      intDestIdx <= '0;
      intResult  <= '0;
      crOut      <= '0;
    end else begin
      resValid   <= issueValid;
      intWrEn    <= issueValid & strobe.act & (strobe.variant == VAR_CR2INT);
      crWrEn     <= issueValid & strobe.act & (strobe.variant != VAR_CR2INT);
      intDestIdx <= strobe.regIdx;
      intResult  <= {{(XLEN-1){1'b0}}, reduced};
      crOut      <= crNext;
    end
  end
endmodule

// File: rtl/cfmc_unit.sv
module cfmc_unit
  import cfmc_pkg::*;
#(
  parameter int         XLEN   = 64,
  parameter logic [4:0] SUB_OP = 5'b01011
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic [31:0]     instrWord,
  input  logic [CR_W-1:0] crIn,
  input  logic [XLEN-1:0] srcVal,
  output logic [4:0]      srcRegIdx,
  output logic            resValid,
  output logic            intWrEn,
  output logic [4:0]      intDestIdx,
  output logic [XLEN-1:0] intResult,
  output logic            crWrEn,
  output logic [CR_W-1:0] crOut
);
  cfmcStrobe_t strobe;

  cfmc_ctrl #(.PRIMARY_OP(6'd19), .SUB_OP(SUB_OP)) u_ctrl (
    .instrWord(instrWord),
    .strobe   (strobe)
  );

  assign srcRegIdx = strobe.regIdx;

  cfmc_datapath #(.XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .strobe    (strobe),
    .crIn      (crIn),
    .srcVal    (srcVal),
    .resValid  (resValid),
    .intWrEn   (intWrEn),
    .intDestIdx(intDestIdx),
    .intResult (intResult),
    .crWrEn    (crWrEn),
    .crOut     (crOut)
  );
endmodule

// File: rtl/cfmc_checker.sv
module cfmc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        issueValid,
  input logic [31:0] instrWord,
  input logic [31:0] crIn,
  input logic        resValid,
  input logic        intWrEn,
  input logic [63:0] intResult,
  input logic        crWrEn,
  input logic [31:0] crOut
);
  logic [31:0] prevIns;
  logic [31:0] prevCr;
  logic [2:0]  prevTarget;
  logic [31:0] keepMask;
  logic [3:0]  targetNib;
  logic [3:0]  immNib;
  logic        prevImmZero;

  always_ff @(posedge clk) begin
    prevIns <= instrWord;
    prevCr  <= crIn;
  end

  always_comb begin
    if (!prevIns[12])     prevTarget = prevIns[15:13];
    else if (!prevIns[20]) prevTarget = prevIns[25:23];
    else                  prevTarget = prevIns[23:21];
    keepMask  = ~(32'hF << {prevTarget, 2'b00});
    targetNib = 4'(crOut >> {prevTarget, 2'b00});
    immNib    = prevIns[19:16] & ~prevIns[4:1];
    prevImmZero = prevIns[20] & !prevIns[12] & (prevIns[25:21] == 5'd0);
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> resValid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> !resValid && !intWrEn && !crWrEn);
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({intWrEn, crWrEn}));
  a_r5_int_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    intWrEn |-> intResult[63:1] == 63'd0);
  a_r9_others_kept: assert property (@(posedge clk) disable iff (!rstN)
    crWrEn |-> ((crOut ^ prevCr) & keepMask) == 32'd0);
  a_r8_one_bit_moves: assert property (@(posedge clk) disable iff (!rstN)
    (crWrEn && prevIns[20] && prevIns[12]) |-> $countones(crOut ^ prevCr) <= 1);
  a_r10_immediate_field: assert property (@(posedge clk) disable iff (!rstN)
    (crWrEn && prevImmZero) |-> targetNib == immNib);
endmodule

bind cfmc_unit cfmc_checker u_chk (.*);

// File: tb/cfmc_unit_bench.sv
module cfmc_unit_bench;
  localparam logic [4:0] SUB = 5'b01011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] crIn = '0;
  logic [63:0] srcVal = '0;
  logic [4:0]  srcRegIdx;
  logic        resValid;
  logic        intWrEn;
  logic [4:0]  intDestIdx;
  logic [63:0] intResult;
  logic        crWrEn;
  logic [31:0] crOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cfmc_unit u_cfmc_unit (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkIns(input logic a, input logic b, input logic [4:0] f5,
                                        input logic [3:0] maskSeq, input logic [2:0] bb,
                                        input logic m, input logic [3:0] modeSeq);
    return {6'd19, f5, a, maskSeq, bb, b, m, SUB, 1'b0, modeSeq, 1'b0};
  endfunction

  // behavioural reference, big-endian field positions read directly
  function automatic logic mb(input logic [31:0] w, input int k);
    return w[31-k];
  endfunction

  logic        eValid, eInt, eCr;
  logic [63:0] eRes;
  logic [4:0]  eIdx;
  logic [31:0] eCrOut;

  task automatic model(input logic [31:0] w, input logic [31:0] cr, input logic [63:0] sv, input logic v);
    int opc, sub, a, b, m, bb, hi5;
    int n[4];
    int src[4];
    int red;
    opc = 0; sub = 0; bb = 0; hi5 = 0;
    for (int k = 0; k <= 5; k++) opc = opc * 2 + mb(w, k);
    for (int k = 21; k <= 25; k++) sub = sub * 2 + mb(w, k);
    for (int k = 16; k <= 18; k++) bb = bb * 2 + mb(w, k);
    for (int k = 6; k <= 10; k++) hi5 = hi5 * 2 + mb(w, k);
    a = mb(w, 11); b = mb(w, 19); m = mb(w, 20);
    for (int i = 0; i < 4; i++) begin
      if (a == 1 && b == 0) src[i] = (hi5 == 0) ? 0 : int'(sv[0]);
      else src[i] = cr[4*bb + 3 - i];
      n[i] = mb(w, 12 + i) & ((mb(w, 27 + i) == src[i]) ? 1 : 0);
    end
    red = m ? (n[0] | n[1] | n[2] | n[3]) : (n[0] & n[1] & n[2] & n[3]);
    eValid = v;
    eInt = v && opc == 19 && sub == int'(SUB) && mb(w, 26) == 0 && a == 0 && b == 0;
    eCr  = v && opc == 19 && sub == int'(SUB) && mb(w, 26) == 0 && !(a == 0 && b == 0);
    eRes = 64'(red);
    eIdx = 5'(hi5);
    eCrOut = cr;
    if (a == 1 && b == 0)
      for (int i = 0; i < 4; i++) eCrOut[4*bb + 3 - i] = n[i][0];
    else if (a == 0 && b == 1)
      for (int i = 0; i < 4; i++) eCrOut[4*(hi5 >> 2) + 3 - i] = n[i][0];
    else if (a == 1 && b == 1)
      eCrOut[4*(hi5 & 7) + 3 - (hi5 >> 3)] = red[0];
  endtask

  task automatic step(input logic [31:0] w, input logic [31:0] cr, input logic [63:0] sv,
                      input logic v, input string tag);
    @(negedge clk);
    instrWord = w; crIn = cr; srcVal = sv; issueValid = v;
    model(w, cr, sv, v);
    @(negedge clk);
    check({tag, " R2 resValid"}, 64'(resValid), 64'(eValid));
    check({tag, " R1 intWrEn"}, 64'(intWrEn), 64'(eInt));
    check({tag, " R1 crWrEn"}, 64'(crWrEn), 64'(eCr));
    check({tag, " R6 srcRegIdx"}, 64'(srcRegIdx), 64'(w[25:21]));
    if (eInt) begin
      check({tag, " R5 intResult"}, intResult, eRes);
      check({tag, " R5 intDestIdx"}, 64'(intDestIdx), 64'(eIdx));
    end
    if (eCr) check({tag, " R9 crOut"}, 64'(crOut), 64'(eCrOut));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset resValid", 64'(resValid), 64'd0);
    check("R2 reset intWrEn", 64'(intWrEn), 64'd0);
    check("R2 reset crWrEn", 64'(crWrEn), 64'd0);
    rstN = 1'b1;

    // R10 set / clear / load pattern with literal-zero source
    step(mkIns(1, 0, 5'd0, 4'b1010, 3'd5, 0, 4'b0000), 32'h0, 64'h1, 1, "R10 set");
    check("R10 set field", 64'(crOut), 64'h00A00000);
    step(mkIns(1, 0, 5'd0, 4'b1111, 3'd2, 0, 4'b1111), 32'hFFFFFFFF, 64'h1, 1, "R10 clear");
    check("R10 clear field", 64'(crOut), 64'hFFFFF0FF);
    step(mkIns(1, 0, 5'd0, 4'b1111, 3'd7, 0, 4'b1001), 32'h0, 64'h0, 1, "R10 load");
    check("R10 load pattern", 64'(crOut), 64'h60000000);
    // R6 register source vs literal zero
    step(mkIns(1, 0, 5'd3, 4'b1111, 3'd1, 0, 4'b1010), 32'h0, 64'h1, 1, "R6 reg");
    check("R6 lsb one", 64'(crOut), 64'h000000A0);
    step(mkIns(1, 0, 5'd0, 4'b1111, 3'd1, 0, 4'b1010), 32'h0, 64'h1, 1, "R6 zero");
    check("R6 literal zero", 64'(crOut), 64'h00000050);
    // R3 / R5 reductions
    step(mkIns(0, 0, 5'd9, 4'b1111, 3'd3, 0, 4'b1001), 32'h00009000, 64'h0, 1, "R5 and");
    check("R3 and all equal", intResult, 64'd1);
    check("R5 dest index", 64'(intDestIdx), 64'd9);
    step(mkIns(0, 0, 5'd9, 4'b1111, 3'd3, 0, 4'b1101), 32'h00009000, 64'h0, 1, "R5 and0");
    check("R3 and one mismatch", intResult, 64'd0);
    step(mkIns(0, 0, 5'd9, 4'b1111, 3'd3, 1, 4'b1101), 32'h00009000, 64'h0, 1, "R5 or");
    check("R3 or some match", intResult, 64'd1);
    step(mkIns(0, 0, 5'd9, 4'b0000, 3'd3, 1, 4'b1001), 32'h00009000, 64'h0, 1, "R5 or0");
    check("R3 or with empty mask", intResult, 64'd0);
    // R7 field-to-field over contrasting background
    step(mkIns(0, 1, 5'b10000, 4'b1111, 3'd1, 0, 4'b1111), 32'h000000C0, 64'h0, 1, "R7 full");
    check("R7 whole field", 64'(crOut), 64'h000C00C0);
    step(mkIns(0, 1, 5'b10000, 4'b1011, 3'd1, 0, 4'b1111), 32'h000000C0, 64'h0, 1, "R7 part");
    check("R7 masked field", 64'(crOut), 64'h000800C0);
    // R8 single bit
    step(mkIns(1, 1, 5'b10110, 4'b1111, 3'd0, 0, 4'b0000), 32'h0, 64'h0, 1, "R8 eq");
    check("R8 single bit set", 64'(crOut), 64'h02000000);
    step(mkIns(1, 1, 5'b00000, 4'b1111, 3'd0, 0, 4'b1111), 32'hFFFFFFF0, 64'h0, 1, "R8 lt");
    check("R8 lt bit cleared only", 64'(crOut), 64'hFFFFFFF0);
    // R1 undecoded words
    step({6'd18, mkIns(0, 0, 5'd1, 4'b1111, 3'd0, 1, 4'b0000)[25:0]}, 32'h0, 64'h0, 1, "R1 op");
    step(mkIns(0, 1, 5'd4, 4'b1111, 3'd0, 1, 4'b0000) | 32'h20, 32'h0, 64'h0, 1, "R1 bit26");
    step(mkIns(0, 1, 5'd4, 4'b1111, 3'd0, 1, 4'b0000), 32'h0, 64'h0, 0, "R2 idle");

    for (int t = 0; t < 3000; t++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 9) != 0) begin
        w[31:26] = 6'd19;
        w[10:6]  = SUB;
        w[5]     = 1'b0;
      end
      if ($urandom_range(0, 3) == 0) w[25:21] = 5'd0;
      step(w, $urandom, {$urandom, $urandom}, $urandom_range(0, 7) != 0, "rand R3 R4 R7 R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule